// File: doc/BRIEF.md
# Control Pin Conditioning and Mode Logic

This block takes two slow external control pins, a sleep-control pin and a dual-purpose pin, and turns them into clean internal requests. Each pin first passes through a two-flop synchronizer and then a bidirectional deglitch filter. A level change, in either direction, reaches the filter output only after it has held for `FILT_CYC` consecutive clock cycles. The filtered levels are available as status bits before any polarity is applied.

The sleep pin, after its polarity select, drives a two-state power state machine. The states are `ST_ACTIVE` and `ST_SLEEP`. Transition `GO_SLEEP` moves from `ST_ACTIVE` to `ST_SLEEP` when the pin is deasserted, and transition `WAKE` moves from `ST_SLEEP` to `ST_ACTIVE` when it is asserted. Both transitions need the power-down enable bit set and the sleep-pin mode bit clear; otherwise the state holds.

The dual pin serves one of two roles, chosen by a scaling-enable bit. In the first role it is an external power-good input with its own polarity, routed to the reset logic. In the second role it is a voltage-set select for all buck regulators. That select follows the pin only while the machine is in `ST_ACTIVE`, and polarity has no effect in this role. All configuration bits are static register fields.

Top module: `ctl_pin_cond`

## Requirements
- R1: A level change on either pin appears on its status bit exactly FILT_CYC+2 clock cycles after the pin changes, provided it is held. A pulse shorter than FILT_CYC cycles never reaches the status bit.
- R2: After reset both status bits read 0, `pwr_active` is 1, `sleep_req` is 0 and `vset_sel` is 0.
- R3: While `cfg_pdn_en` is 0 the power state never changes, whatever the sleep pin does.
- R4: With `cfg_pdn_en`=1 and `cfg_slp_mode`=0, the sleep pin is asserted when its filtered level XOR `cfg_slp_pol` is 1 (pol 0 = active high, pol 1 = active low). One cycle after the filtered level changes, the state becomes `ST_ACTIVE` if the pin is asserted and `ST_SLEEP` if it is not. `pwr_active` is 1 in `ST_ACTIVE`, and `sleep_req` is 1 in `ST_SLEEP`.
- R5: While `cfg_slp_mode` is 1 the sleep pin does not change the power state.
- R6: With `cfg_dvs_en`=0, `ext_pg_ok` equals the dual pin's filtered level XOR `cfg_dual_pol` (pol 0 = active high, pol 1 = active low), and `vset_sel` is 0.
- R7: With `cfg_dvs_en`=1, `ext_pg_ok` is 0 and `cfg_dual_pol` has no effect on any output.
- R8: With `cfg_dvs_en`=1 in `ST_ACTIVE`, `vset_sel` equals the dual pin's filtered level (0 selects VSET0, 1 selects VSET1).
- R9: Whenever the state is `ST_SLEEP`, `vset_sel` is 0 (VSET0).
- R10: `stat_slp_pin` and `stat_dual_pin` show the filtered pin levels without polarity applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_pin | input | 1 | Raw sleep-control pin |
| dual_pin | input | 1 | Raw dual-purpose pin (power good or voltage-set control) |
| cfg_pdn_en | input | 1 | Power-down enable; the sleep pin is ignored while 0 |
| cfg_slp_pol | input | 1 | Sleep pin polarity: 0 active high, 1 active low |
| cfg_slp_mode | input | 1 | Sleep pin mode: 0 sleep/active control, 1 pin has no state effect |
| cfg_dual_pol | input | 1 | Dual pin power-good polarity: 0 active high, 1 active low |
| cfg_dvs_en | input | 1 | 1 selects voltage-set role for the dual pin |
| stat_slp_pin | output | 1 | Filtered sleep pin level |
| stat_dual_pin | output | 1 | Filtered dual pin level |
| sleep_req | output | 1 | 1 while in ST_SLEEP |
| pwr_active | output | 1 | 1 while in ST_ACTIVE |
| ext_pg_ok | output | 1 | External power good toward the reset logic |
| vset_sel | output | 1 | Voltage-set select for all bucks: 0 VSET0, 1 VSET1 |

## Verification
The assertions check on every cycle that a filter output only flips after a full run of disagreeing synchronized samples. They also check that the power state holds when the power-down enable is clear or the mode bit is set, that power good stays low in scaling mode, and that VSET0 is held outside `ST_ACTIVE` or outside scaling mode. The exact FILT_CYC+2 latency, the rejection of short glitches, the polarity mapping of each pin and the `GO_SLEEP`/`WAKE` timing can only be shown by the bench scenarios. Those scenarios compare every output against a cycle model across random pin activity and configurations.

// File: rtl/ctl_pin_pkg.sv
package ctl_pin_pkg;

    typedef enum logic [0:0] {
        ST_ACTIVE = 1'b0,
        ST_SLEEP  = 1'b1
    } pwr_st_e;

    localparam int unsigned NPIN     = 2;
    localparam int unsigned PIN_SLP  = 0;
    localparam int unsigned PIN_DUAL = 1;

    typedef struct packed {
        logic pdn_en;
        logic slp_pol;
        logic slp_mode;
        logic dual_pol;
        logic dvs_en;
    } pin_cfg_t;

endpackage

// File: rtl/ctl_sync2.sv
module ctl_sync2 #(
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_LVL;
            sync_q <= RST_LVL;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/ctl_deglitch.sv
module ctl_deglitch #(
    parameter int unsigned FILT_CYC = 1250,
    parameter logic        RST_LVL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    localparam int unsigned CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LIM = CW'(FILT_CYC - 1);

    logic          lvl_q;
    logic [CW-1:0] run_q;

    // Counts consecutive cycles the input disagrees with the held level;
    // any agreeing sample restarts the window, so both edges are filtered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= RST_LVL;
            run_q <= '0;
        end else if (d_in == lvl_q) begin
            run_q <= '0;
        end else if (run_q == CNT_LIM) begin
            lvl_q <= d_in;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign q_out = lvl_q;

endmodule

// File: rtl/ctl_pwr_fsm.sv
module ctl_pwr_fsm
    import ctl_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t cfg,
    input  logic     slp_lvl,
    input  logic     dual_lvl,
    output logic     sleep_req,
    output logic     pwr_active,
    output logic     ext_pg_ok,
    output logic     vset_sel
);

    pwr_st_e st_q;
    pwr_st_e st_d;
    logic    slp_asserted;
    logic    slp_ctl_on;

    assign slp_asserted = slp_lvl ^ cfg.slp_pol;
    assign slp_ctl_on   = cfg.pdn_en && !cfg.slp_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_ACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACTIVE: if (slp_ctl_on && !slp_asserted) st_d = ST_SLEEP;   // GO_SLEEP
            ST_SLEEP:  if (slp_ctl_on &&  slp_asserted) st_d = ST_ACTIVE;  // WAKE
            default:   st_d = ST_ACTIVE;
        endcase
    end

    always_comb begin
        sleep_req  = 1'b0;
        pwr_active = 1'b0;
        ext_pg_ok  = cfg.dvs_en ? 1'b0 : (dual_lvl ^ cfg.dual_pol);
        vset_sel   = 1'b0;
        unique case (st_q)
            ST_ACTIVE: begin
                pwr_active = 1'b1;
                vset_sel   = cfg.dvs_en & dual_lvl;
            end
            ST_SLEEP: begin
                sleep_req = 1'b1;
            end
            default: begin
                sleep_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctl_pin_cond.sv
module ctl_pin_cond
    import ctl_pin_pkg::*;
#(
    parameter int unsigned FILT_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slp_pin,
    input  logic dual_pin,
    input  logic cfg_pdn_en,
    input  logic cfg_slp_pol,
    input  logic cfg_slp_mode,
    input  logic cfg_dual_pol,
    input  logic cfg_dvs_en,
    output logic stat_slp_pin,
    output logic stat_dual_pin,
    output logic sleep_req,
    output logic pwr_active,
    output logic ext_pg_ok,
    output logic vset_sel
);

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] pin_filt;
    logic            slp_sync;
    logic            slp_filt;
    logic            dual_sync;
    logic            dual_filt;
    pin_cfg_t        cfg;

    assign pin_raw[PIN_SLP]  = slp_pin;
    assign pin_raw[PIN_DUAL] = dual_pin;

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        ctl_sync2 #(.RST_LVL(1'b0)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_async(pin_raw[gi]),
            .q_sync (pin_sync[gi])
        );
        ctl_deglitch #(.FILT_CYC(FILT_CYC), .RST_LVL(1'b0)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .d_in (pin_sync[gi]),
            .q_out(pin_filt[gi])
        );
    end

    assign slp_sync  = pin_sync[PIN_SLP];
    assign slp_filt  = pin_filt[PIN_SLP];
    assign dual_sync = pin_sync[PIN_DUAL];
    assign dual_filt = pin_filt[PIN_DUAL];

    assign cfg = '{pdn_en:   cfg_pdn_en,
                   slp_pol:  cfg_slp_pol,
                   slp_mode: cfg_slp_mode,
                   dual_pol: cfg_dual_pol,
                   dvs_en:   cfg_dvs_en};

    ctl_pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .slp_lvl   (slp_filt),
        .dual_lvl  (dual_filt),
        .sleep_req (sleep_req),
        .pwr_active(pwr_active),
        .ext_pg_ok (ext_pg_ok),
        .vset_sel  (vset_sel)
    );

    assign stat_slp_pin  = slp_filt;
    assign stat_dual_pin = dual_filt;

endmodule

// File: rtl/ctl_pin_chk.sv
module ctl_pin_chk #(
    parameter int unsigned FILT_CYC = 1250
) (
    input logic clk,
    input logic rst_n,
    input logic slp_sync,
    input logic slp_filt,
    input logic dual_sync,
    input logic dual_filt,
    input logic cfg_pdn_en,
    input logic cfg_slp_mode,
    input logic cfg_dvs_en,
    input logic pwr_active,
    input logic ext_pg_ok,
    input logic vset_sel
);

    localparam int unsigned RW = $clog2(FILT_CYC + 2) + 1;
    localparam logic [RW-1:0] RUN_MAX = RW'(FILT_CYC);
    localparam logic [RW-1:0] RUN_MIN = RW'(FILT_CYC - 1);

    logic [RW-1:0] slp_run_q;
    logic [RW-1:0] dual_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slp_run_q  <= '0;
            dual_run_q <= '0;
        end else begin
            slp_run_q  <= (slp_sync == slp_filt) ? '0 :
                          ((slp_run_q == RUN_MAX) ? slp_run_q : slp_run_q + 1'b1);
            dual_run_q <= (dual_sync == dual_filt) ? '0 :
                          ((dual_run_q == RUN_MAX) ? dual_run_q : dual_run_q + 1'b1);
        end
    end

    a_r1_slp_window: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slp_filt) |-> ($past(slp_run_q) >= RUN_MIN));

    a_r1_dual_window: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dual_filt) |-> ($past(dual_run_q) >= RUN_MIN));

    a_r3_hold_no_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pdn_en |=> $stable(pwr_active));

    a_r5_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_slp_mode |=> $stable(pwr_active));

    a_r7_no_pg_in_dvs: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dvs_en |-> !ext_pg_ok);

    a_r9_vset0_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_active |-> !vset_sel);

    a_r6_vset0_pg_role: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dvs_en |-> !vset_sel);

endmodule

bind ctl_pin_cond ctl_pin_chk #(.FILT_CYC(FILT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slp_sync    (slp_sync),
    .slp_filt    (slp_filt),
    .dual_sync   (dual_sync),
    .dual_filt   (dual_filt),
    .cfg_pdn_en  (cfg_pdn_en),
    .cfg_slp_mode(cfg_slp_mode),
    .cfg_dvs_en  (cfg_dvs_en),
    .pwr_active  (pwr_active),
    .ext_pg_ok   (ext_pg_ok),
    .vset_sel    (vset_sel)
);

// File: tb/tb_ctl_pin_cond.sv
`timescale 1ns/1ps
module tb_ctl_pin_cond;

    localparam int unsigned FILT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slp_pin = 1'b0, dual_pin = 1'b0;
    logic cfg_pdn_en = 1'b0, cfg_slp_pol = 1'b0, cfg_slp_mode = 1'b0;
    logic cfg_dual_pol = 1'b0, cfg_dvs_en = 1'b0;
    logic stat_slp_pin, stat_dual_pin, sleep_req, pwr_active, ext_pg_ok, vset_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctl_pin_cond #(.FILT_CYC(FILT)) dut (
        .clk(clk), .rst_n(rst_n), .slp_pin(slp_pin), .dual_pin(dual_pin),
        .cfg_pdn_en(cfg_pdn_en), .cfg_slp_pol(cfg_slp_pol), .cfg_slp_mode(cfg_slp_mode),
        .cfg_dual_pol(cfg_dual_pol), .cfg_dvs_en(cfg_dvs_en),
        .stat_slp_pin(stat_slp_pin), .stat_dual_pin(stat_dual_pin),
        .sleep_req(sleep_req), .pwr_active(pwr_active),
        .ext_pg_ok(ext_pg_ok), .vset_sel(vset_sel)
    );

    // Cycle model from the requirements: 2 sync stages, FILT-cycle window, state one cycle later
    logic [1:0] m_s1, m_s2, m_lvl;
    int         m_run [2];
    logic       m_act;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_lvl <= '0; m_act <= 1'b1;
            m_run[0] <= 0; m_run[1] <= 0;
        end else begin
            m_s1 <= {dual_pin, slp_pin};
            m_s2 <= m_s1;
            for (int i = 0; i < 2; i++) begin
                if (m_s2[i] == m_lvl[i]) m_run[i] <= 0;
                else if (m_run[i] == FILT - 1) begin m_lvl[i] <= m_s2[i]; m_run[i] <= 0; end
                else m_run[i] <= m_run[i] + 1;
            end
            if (cfg_pdn_en && !cfg_slp_mode) m_act <= m_lvl[0] ^ cfg_slp_pol;
        end
    end

    function automatic logic exp_pg(logic lvl, logic pol, logic dvs);
        return dvs ? 1'b0 : (lvl ^ pol);
    endfunction

    function automatic logic exp_vset(logic lvl, logic act, logic dvs);
        return (dvs && act) ? lvl : 1'b0;
    endfunction

    task automatic chk(string tag, logic got, logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic cmp_all();
        chk("R10 slp status", stat_slp_pin, m_lvl[0]);
        chk("R1 dual status", stat_dual_pin, m_lvl[1]);
        if (!cfg_pdn_en)       chk("R3 state hold", pwr_active, m_act);
        else if (cfg_slp_mode) chk("R5 state hold", pwr_active, m_act);
        else                   chk("R4 state", pwr_active, m_act);
        chk("R4 sleep_req", sleep_req, !m_act);
        if (cfg_dvs_en) chk("R7 pg in dvs", ext_pg_ok, 1'b0);
        else            chk("R6 pg", ext_pg_ok, exp_pg(m_lvl[1], cfg_dual_pol, 1'b0));
        if (!m_act)          chk("R9 vset sleep", vset_sel, 1'b0);
        else if (cfg_dvs_en) chk("R8 vset", vset_sel, exp_vset(m_lvl[1], m_act, 1'b1));
        else                 chk("R6 vset", vset_sel, 1'b0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 slp status", stat_slp_pin, 1'b0);
        chk("R2 dual status", stat_dual_pin, 1'b0);
        chk("R2 active", pwr_active, 1'b1);
        chk("R2 sleep_req", sleep_req, 1'b0);
        chk("R2 vset", vset_sel, 1'b0);

        // R1 latency: held change visible exactly FILT+2 edges later
        slp_pin = 1'b1;
        for (int k = 1; k <= FILT + 2; k++) begin
            step();
            if (k == FILT + 1) chk("R1 before window", stat_slp_pin, 1'b0);
            if (k == FILT + 2) chk("R1 at window", stat_slp_pin, 1'b1);
        end

        // R1 glitch of FILT-1 cycles on dual pin is rejected
        dual_pin = 1'b1;
        repeat (FILT - 1) step();
        dual_pin = 1'b0;
        for (int k = 0; k < 3 * FILT; k++) begin
            step();
            chk("R1 glitch rejected", stat_dual_pin, 1'b0);
        end

        // R4 active-low sleep pin: level 1 with pol 1 means deasserted -> sleep
        cfg_slp_pol = 1'b1;
        cfg_pdn_en  = 1'b1;
        step();
        chk("R4 go sleep", sleep_req, 1'b1);
        // R9 / R7: dvs on while asleep, dual pin high
        cfg_dvs_en = 1'b1;
        dual_pin = 1'b1;
        repeat (FILT + 4) step();
        chk("R9 vset0 asleep", vset_sel, 1'b0);
        chk("R7 pg low", ext_pg_ok, 1'b0);
        slp_pin = 1'b0;
        repeat (FILT + 3) step();
        chk("R4 wake", pwr_active, 1'b1);
        chk("R8 vset1", vset_sel, 1'b1);
        cfg_dual_pol = 1'b1;
        step();
        chk("R7 pol no effect", vset_sel, 1'b1);

        // Random phases
        for (int ph = 0; ph < 24; ph++) begin
            cfg_pdn_en   = ($urandom_range(0, 3) != 0);
            cfg_slp_pol  = $urandom_range(0, 1);
            cfg_slp_mode = ($urandom_range(0, 4) == 0);
            cfg_dual_pol = $urandom_range(0, 1);
            cfg_dvs_en   = $urandom_range(0, 1);
            for (int c = 0; c < 400; c++) begin
                if ($urandom_range(0, 9) == 0) slp_pin  = ~slp_pin;
                if ($urandom_range(0, 9) == 0) dual_pin = ~dual_pin;
                step();
                cmp_all();
            end
        end
        summary();
    end

endmodule